// File: doc/BRIEF.md
# LPC SYNC Phase Timeout Monitor

This block sits on the host side of an LPC link and follows the SYNC phase that a target drives on the four-bit LAD bus once the host has handed the bus over. It starts on a one-cycle start strobe that carries the number of bytes in the access. From then on it reads one LAD nibble per clock and sorts it into one of five groups: ready, short wait, long wait, error, or not a SYNC code at all. It counts the wait states and the bad nibbles. For each byte it settles on one of three results: the byte finished, the byte finished with an error, or the host has to abort the cycle.

After each ready or error code the block marks the next two nibbles as data. A cycle of several bytes repeats SYNC and two data nibbles for each byte. An error code closes the whole access once its two data nibbles have passed. The block only requests an abort. The frame signalling that carries the abort out, and all address and data handling, belong to the host sequencer that sits around it.

Top module: `lpc_sync_monitor`

## Requirements
- R1: After reset all outputs are low. While no access is open, LAD nibbles produce no output.
- R2: A ready code, either 4'b0000 or 4'b1001, seen during SYNC makes data_valid_o high in the next two cycles. For the last byte, done_o pulses in the cycle after the second data nibble, with error_o low.
- R3: A run of up to 8 short-wait codes (4'b0101) in one byte's SYNC phase is accepted. The 9th such code in the same byte sets abort_o in the following cycle. A ready or error code resets this count for the next byte.
- R4: Long-wait codes (4'b0110) never cause a timeout, however many of them arrive.
- R5: Three consecutive nibbles that are not one of the five SYNC codes set abort_o in the cycle after the third. Any valid wait code restarts this count.
- R6: After an error code (4'b1010) the next two nibbles are still marked as data. done_o and error_o then pulse together in the following cycle.
- R7: An access of nbytes_i bytes (0 counts as 1) runs SYNC plus two data nibbles for each byte, and done_o follows the last byte. An error code in any byte ends the access after that byte, and the nibbles that follow are ignored.
- R8: Short-wait and long-wait codes must not be mixed within one access, across all of its bytes. The first code of the other kind sets abort_o in the next cycle.
- R9: abort_o can only follow a nibble sampled during SYNC, never a data nibble, and never together with done_o. After an abort the block ignores LAD until the next start strobe.
- R10: start_i opens a new access at any time. It clears the wait counts and the chosen wait kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-SYNC-phase strobe; SYNC sampling begins in the next cycle |
| nbytes_i | input | CNT_W | Byte count of the access, taken with start_i |
| lad_i | input | 4 | Sampled LAD nibble |
| data_valid_o | output | 1 | The current lad_i nibble is a data nibble |
| done_o | output | 1 | One-cycle pulse: access complete |
| error_o | output | 1 | Pulses with done_o when the access ended on an error code |
| abort_o | output | 1 | One-cycle pulse: host must abort the cycle |

## Verification
Each access is driven as a nibble script, and a scoreboard predicts each data strobe, completion and abort down to the exact cycle. The main runs are as follows:
- Ready codes with no waits, with a few short waits and with long waits. These separate the two ready values and the wait kinds.
- Runs of exactly 8 and of 9 short waits. These locate the short-wait limit.
- Two and three bad nibbles in a row, and bad nibbles broken up by wait codes. These show the count must be consecutive.
- Multi-byte accesses that end cleanly, end on an error, or switch wait kind between bytes. These show that state is kept per access.
- Nibbles driven after completion, after an abort and before a restart. Any stray output event in these runs is flagged.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;
  typedef enum logic [2:0] {K_READY, K_SHORT, K_LONG, K_ERR, K_BAD} kind_e;
  typedef enum logic [1:0] {M_NONE, M_SHORT, M_LONG} mode_e;
  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_DLO, S_DHI} state_e;

  localparam logic [3:0] CODE_READY_A = 4'b0000;
  localparam logic [3:0] CODE_READY_B = 4'b1001;
  localparam logic [3:0] CODE_SHORT   = 4'b0101;
  localparam logic [3:0] CODE_LONG    = 4'b0110;
  localparam logic [3:0] CODE_ERR     = 4'b1010;
endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
  import lpc_sync_pkg::*;
(
  input  logic [3:0] lad_i,
  output kind_e      kind_o
);
  always_comb begin
    unique case (lad_i)
      CODE_READY_A, CODE_READY_B: kind_o = K_READY;
      CODE_SHORT:                 kind_o = K_SHORT;
      CODE_LONG:                  kind_o = K_LONG;
      CODE_ERR:                   kind_o = K_ERR;
      default:                    kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/lpc_sync_wait_ctr.sv
module lpc_sync_wait_ctr
  import lpc_sync_pkg::*;
#(
  parameter int SHORT_LIMIT = 8,
  parameter int BAD_LIMIT   = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  sample_i,
  input  kind_e kind_i,
  output logic  trip_o
);
  localparam int SW = $clog2(SHORT_LIMIT + 1);
  localparam int BW = $clog2(BAD_LIMIT + 1);

  logic [SW-1:0] short_q;
  logic [BW-1:0] bad_q;
  mode_e         mode_q;

  logic bad_trip, short_trip, long_trip;
  assign bad_trip   = (kind_i == K_BAD) && (bad_q == BW'(BAD_LIMIT - 1));
  assign short_trip = (kind_i == K_SHORT) &&
                      ((mode_q == M_LONG) || (short_q == SW'(SHORT_LIMIT)));
  assign long_trip  = (kind_i == K_LONG) && (mode_q == M_SHORT);
  assign trip_o     = sample_i && (bad_trip || short_trip || long_trip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_q <= '0;
      bad_q   <= '0;
      mode_q  <= M_NONE;
    end else if (clr_i) begin
      short_q <= '0;
      bad_q   <= '0;
      mode_q  <= M_NONE;
    end else if (sample_i && !trip_o) begin
      unique case (kind_i)
        K_READY, K_ERR: begin
          short_q <= '0;
          bad_q   <= '0;
        end
        K_SHORT: begin
          short_q <= short_q + SW'(1);
          bad_q   <= '0;
          mode_q  <= M_SHORT;
        end
        K_LONG: begin
          bad_q  <= '0;
          mode_q <= M_LONG;
        end
        default: bad_q <= bad_q + BW'(1);
      endcase
    end
  end

  AST_BAD_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (bad_q < BW'(BAD_LIMIT))); // R5
  AST_SHORT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !clr_i && kind_i == K_SHORT && !trip_o) |=> (short_q == $past(short_q) + SW'(1))); // R3
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != M_NONE && !clr_i) |=> (mode_q == $past(mode_q))); // R8
endmodule

// File: rtl/lpc_sync_seq.sv
module lpc_sync_seq
  import lpc_sync_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  kind_e            kind_i,
  input  logic             trip_i,
  output logic             sample_o,
  output logic             data_valid_o,
  output logic             done_o,
  output logic             error_o,
  output logic             abort_o
);
  state_e           state_q;
  logic [CNT_W-1:0] left_q;
  logic             err_q, done_q, erro_q, abort_q;

  assign sample_o     = (state_q == S_SYNC) && !start_i;
  assign data_valid_o = (state_q == S_DLO) || (state_q == S_DHI);
  assign done_o       = done_q;
  assign error_o      = erro_q;
  assign abort_o      = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      left_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      erro_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      erro_q  <= 1'b0;
      abort_q <= 1'b0;
      if (start_i) begin
        state_q <= S_SYNC;
        left_q  <= (nbytes_i == '0) ? CNT_W'(1) : nbytes_i;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_SYNC: begin
            if (trip_i) begin
              abort_q <= 1'b1;
              state_q <= S_IDLE;
            end else if (kind_i == K_READY) begin
              state_q <= S_DLO;
            end else if (kind_i == K_ERR) begin
              err_q   <= 1'b1;
              state_q <= S_DLO;
            end
          end
          S_DLO: state_q <= S_DHI;
          S_DHI: begin
            if (left_q <= CNT_W'(1) || err_q) begin
              done_q  <= 1'b1;
              erro_q  <= err_q;
              state_q <= S_IDLE;
            end else begin
              left_q  <= left_q - CNT_W'(1);
              state_q <= S_SYNC;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_ABORT_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(state_q) == S_SYNC)); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o); // R6
  AST_ERR_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DHI && err_q && !start_i) |=> (done_o && error_o && state_q == S_IDLE)); // R7
  AST_DATA_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DLO && !start_i) |=> (state_q == S_DHI)); // R2
endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
  import lpc_sync_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SHORT_LIMIT = 8,
  parameter int BAD_LIMIT   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic [3:0]       lad_i,
  output logic             data_valid_o,
  output logic             done_o,
  output logic             error_o,
  output logic             abort_o
);
  kind_e kind;
  logic  sample, trip;

  lpc_sync_decode i_decode (
    .lad_i  (lad_i),
    .kind_o (kind)
  );

  lpc_sync_wait_ctr #(
    .SHORT_LIMIT (SHORT_LIMIT),
    .BAD_LIMIT   (BAD_LIMIT)
  ) i_wait_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .sample_i (sample),
    .kind_i   (kind),
    .trip_o   (trip)
  );

  lpc_sync_seq #(
    .CNT_W (CNT_W)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .nbytes_i     (nbytes_i),
    .kind_i       (kind),
    .trip_i       (trip),
    .sample_o     (sample),
    .data_valid_o (data_valid_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .abort_o      (abort_o)
  );

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o, data_valid_o})); // R9
endmodule

// File: tb/test_lpc_sync_monitor.sv
`timescale 1ns/1ps
module test_lpc_sync_monitor;
  localparam int CNT_W = 3;
  localparam int EV_DV = 1, EV_DONE = 2, EV_DERR = 3, EV_ABORT = 4, EV_ODD = 5;

  typedef struct {
    int    code;
    int    cyc;
    string tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] nbytes_i = '0;
  logic [3:0]       lad_i = 4'h0;
  logic             data_valid_o, done_o, error_o, abort_o;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  lpc_sync_monitor #(.CNT_W(CNT_W)) i_lpc_sync_monitor (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .nbytes_i     (nbytes_i),
    .lad_i        (lad_i),
    .data_valid_o (data_valid_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .abort_o      (abort_o)
  );

  task automatic observe(input int code);
    exp_t e;
    n_tests++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected event: actual code %0d at cycle %0d, expected none (R1/R7/R9)", code, cyc);
    end else begin
      e = q.pop_front();
      if (e.code != code || e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: actual code %0d cycle %0d, expected code %0d cycle %0d",
                 e.tag, code, cyc, e.code, e.cyc);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (data_valid_o) observe(EV_DV);
      if (done_o) observe(error_o ? EV_DERR : EV_DONE);
      if (abort_o) observe(EV_ABORT);
      if (error_o && !done_o) observe(EV_ODD);
    end
  end

  task automatic push(input int code, input int off, input string tag);
    q.push_back('{code, cyc + off, tag});
  endtask

  task automatic nib(input logic [3:0] v);
    start_i = 1'b0;
    lad_i   = v;
    @(negedge clk_i);
  endtask

  task automatic go(input int n);
    start_i  = 1'b1;
    nbytes_i = CNT_W'(n);
    lad_i    = 4'hF;
    @(negedge clk_i);
  endtask

  // terminating SYNC code plus two data nibbles
  task automatic term_byte(input logic [3:0] code, input bit last, input bit err, input string tag);
    push(EV_DV, 1, tag);
    push(EV_DV, 2, tag);
    if (last) push(err ? EV_DERR : EV_DONE, 3, tag);
    nib(code);
    nib(4'h6);
    nib(4'h5);
  endtask

  task automatic abort_on(input logic [3:0] v, input string tag);
    push(EV_ABORT, 1, tag);
    nib(v);
  endtask

  task automatic settle(input string tag);
    nib(4'h0);
    nib(4'hA);
    nib(4'h9);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual %0d events pending, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_tests++;
    if ({data_valid_o, done_o, error_o, abort_o} != 4'b0) begin
      n_fail++;
      $display("FAIL R1: actual outputs %b, expected 0000", {data_valid_o, done_o, error_o, abort_o});
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    settle("R1 idle nibbles ignored");

    // R2: both ready codes, no waits and short waits
    go(1); term_byte(4'h0, 1, 0, "R2 ready 0000");       settle("R2");
    go(1); nib(4'h5); nib(4'h5); nib(4'h5);
    term_byte(4'h9, 1, 0, "R2 ready 1001 after waits");  settle("R2");

    // R3: limit of short waits
    go(1); repeat (8) nib(4'h5);
    term_byte(4'h0, 1, 0, "R3 eight short waits");       settle("R3");
    go(1); repeat (8) nib(4'h5);
    abort_on(4'h5, "R3 ninth short wait");                settle("R3 after abort");
    go(2); repeat (8) nib(4'h5); term_byte(4'h0, 0, 0, "R3 byte0");
    repeat (8) nib(4'h5); term_byte(4'h9, 1, 0, "R3 per-byte count"); settle("R3");

    // R4: long waits unbounded
    go(1); repeat (40) nib(4'h6);
    term_byte(4'h0, 1, 0, "R4 long waits");              settle("R4");

    // R5: bad nibbles
    go(1); nib(4'hF); nib(4'h3);
    term_byte(4'h0, 1, 0, "R5 two bad nibbles");          settle("R5");
    go(1); nib(4'hF); nib(4'hF); nib(4'h5); nib(4'hF); nib(4'hF); nib(4'h5); nib(4'h1);
    term_byte(4'h9, 1, 0, "R5 non-consecutive bad");      settle("R5");
    go(1); nib(4'hF); nib(4'h3);
    abort_on(4'hC, "R5 three bad nibbles");

    // R9: ignored after abort
    settle("R9 after abort");

    // R6: error SYNC
    go(1); nib(4'h5);
    term_byte(4'hA, 1, 1, "R6 error sync");               settle("R6");

    // R7: multi-byte
    go(4); term_byte(4'h0, 0, 0, "R7 b0"); term_byte(4'h9, 0, 0, "R7 b1");
    nib(4'h6); term_byte(4'h0, 0, 0, "R7 b2"); term_byte(4'h0, 1, 0, "R7 b3");
    settle("R7 full");
    go(4); term_byte(4'h0, 0, 0, "R7 e0");
    term_byte(4'hA, 1, 1, "R7 error ends access");
    nib(4'h0); nib(4'h3); nib(4'h4);
    settle("R7 bytes after error ignored");
    go(0); term_byte(4'h0, 1, 0, "R7 zero count as one"); settle("R7");

    // R8: mixing wait kinds
    go(1); nib(4'h5); nib(4'h5);
    abort_on(4'h6, "R8 short then long");                 settle("R8");
    go(2); nib(4'h6); term_byte(4'h0, 0, 0, "R8 b0");
    abort_on(4'h5, "R8 long then short across bytes");    settle("R8");

    // R10: restart clears counts and wait kind
    go(1); repeat (5) nib(4'h5);
    go(1); repeat (8) nib(4'h5);
    term_byte(4'h0, 1, 0, "R10 short count cleared");     settle("R10");
    go(1); nib(4'h5); nib(4'hF); nib(4'hF);
    go(1); nib(4'h6); nib(4'hF); nib(4'hF);
    term_byte(4'h0, 1, 0, "R10 kind and bad count cleared"); settle("R10");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule